// File: doc/BRIEF.md
# 3x3 Sliding Neighbourhood Generator with Window Qualification

The block accepts a raster-ordered stream of grayscale pixels, one per clock once a frame has started, and presents on every accepted pixel a full 3x3 neighbourhood built from a chain of shift registers that holds two image lines plus two pixels. The newest pixel always sits at the bottom-right corner of the window, and the centre of the window is the pixel one row up and one column left of it.

A controller tracks the row and column of every incoming pixel. It marks a window as usable only when all nine positions hold pixels of the current frame from the same three columns. This rules out the fill period at the start of the frame and every window that would wrap from the end of one line into the start of the next. Unusable windows are driven out as all-zero pixels, so that a downstream gradient stage sees no edge on border pixels. Each usable window receives the next address of a result memory. The write strobe, the address and an end-of-frame pulse are delayed by a parameter so that they line up with the output of downstream arithmetic.

Top module: `pixwin3`

## Requirements
- R1: A pixel is accepted when `sof` is high (it becomes row 0, column 0) or while a frame is in progress. After the pixel at row ROWS-1, column COLS-1 is accepted, further pixels are ignored until the next `sof`. Pixels arriving after reset and before any `sof` are also ignored.
- R2: One clock after a pixel at (r,c) is accepted, `winPix` bits [8k-1:8k-8] carry window position Pk (k=1..9). P1..P3 are row r-2, P4..P6 are row r-1 and P7..P9 are row r, each row left to right over columns c-2..c. P5 is the centre and P9 is the accepted pixel.
- R3: `winValid` is high in that same cycle exactly when r>=2 and c>=2. The first valid window therefore follows the (2*COLS+3)-th pixel of a frame, and windows whose P1 would fall in column COLS-2 or COLS-1 of an earlier line are invalid.
- R4: Whenever `winValid` is low, `winPix` is all zero.
- R5: Valid windows of a frame receive consecutive addresses from 0 to (ROWS-2)*(COLS-2)-1 in arrival order, which gives exactly (ROWS-2)*(COLS-2) valid windows per frame.
- R6: `wrEn` and `wrAddr` repeat the window's valid flag and address exactly ARITH_LAT clocks after `winValid`. `wrAddr` is 0 while `wrEn` is low.
- R7: `frameDone` pulses for one clock together with the `wrEn` that carries address (ROWS-2)*(COLS-2)-1, once per completed frame.
- R8: `sof` in the middle of a frame restarts the pixel position and address count, so the next valid window is written to address 0.
- R9: Active-low reset clears `winPix`, `winValid`, `wrEn`, `wrAddr` and `frameDone` to zero and ends any frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| sof | input | 1 | Marks the first pixel of a frame |
| pixIn | input | PIX_W | Incoming pixel, raster order |
| winPix | output | 9*PIX_W | Window P1..P9, P1 in the low byte |
| winValid | output | 1 | Current window is complete and wrap-free |
| wrEn | output | 1 | Result write strobe, delayed by ARITH_LAT |
| wrAddr | output | ADDR_W | Result address, delayed by ARITH_LAT |
| frameDone | output | 1 | Pulse with the last write of a frame |

## Verification
A wrong column or row count shows within one clock as a valid flag at the wrong position in a line, or as window bytes drawn from the wrong offsets of the shift chain. The bench compares every byte of every window against an image it records itself. A wrong address counter shows at the write port ARITH_LAT clocks later, as a skipped, repeated or non-zero-starting address, and at the end of the frame as a missing or misplaced `frameDone`. An aborted frame and idle pixels after a frame check that restarts and ignored input leave no trace in the following frame.

// File: rtl/pixwin_pkg.sv
package pixwin_pkg;
  // Strobes from the controller to the window datapath
  typedef struct packed {
    logic shift;   // accept pixel into the line chain
    logic winOk;   // window formed by this pixel is usable
  } pwStrobe_t;
endpackage

// File: rtl/pixwin3_ctrl.sv
module pixwin3_ctrl
  import pixwin_pkg::*;
#(
  parameter int COLS      = 1024,
  parameter int ROWS      = 1024,
  parameter int ARITH_LAT = 2,
  parameter int ADDR_W    = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sof,
  output pwStrobe_t         strb,
  output logic              winValid,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic              frameDone
);
  localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1;
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int TOTAL = (ROWS - 2) * (COLS - 2);
  localparam logic [COL_W-1:0]  COL_LAST = COL_W'(COLS - 1);
  localparam logic [ROW_W-1:0]  ROW_LAST = ROW_W'(ROWS - 1);
  localparam logic [ADDR_W-1:0] ADDR_LAST = ADDR_W'(TOTAL - 1);

  logic             running;
  logic [COL_W-1:0] colCnt, curCol;
  logic [ROW_W-1:0] rowCnt, curRow;
  logic [ADDR_W-1:0] addrCnt, curAddr;
  logic accept, winOk, lastPix;

  // Position of the pixel presented this cycle
  always_comb begin
    accept  = sof | running;
    curCol  = sof ? '0 : colCnt;
    curRow  = sof ? '0 : rowCnt;
    curAddr = sof ? '0 : addrCnt;
    winOk   = accept && (curRow >= ROW_W'(2)) && (curCol >= COL_W'(2));
    lastPix = (curRow == ROW_LAST) && (curCol == COL_LAST);
  end

  assign strb.shift = accept;
  assign strb.winOk = winOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      colCnt  <= '0;
      rowCnt  <= '0;
    end else if (accept) begin
      if (lastPix) begin
        running <= 1'b0;
        colCnt  <= '0;
        rowCnt  <= '0;
      end else begin
        running <= 1'b1;
        if (curCol == COL_LAST) begin
          colCnt <= '0;
          rowCnt <= curRow + 1'b1;
        end else begin
          colCnt <= curCol + 1'b1;
          rowCnt <= curRow;
        end
      end
    end
  end

  // Address counter advances only on usable windows
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      addrCnt <= '0;
    else if (winOk) addrCnt <= curAddr + 1'b1;
    else if (sof)   addrCnt <= '0;
  end

  logic              vS1, lS1;
  logic [ADDR_W-1:0] aS1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vS1 <= 1'b0;
      aS1 <= '0;
      lS1 <= 1'b0;
    end else begin
      vS1 <= winOk;
      aS1 <= winOk ? curAddr : '0;
      lS1 <= winOk && (curAddr == ADDR_LAST);
    end
  end

  assign winValid = vS1;

  // Align write side with downstream arithmetic
  generate
    if (ARITH_LAT == 0) begin : g_noLat
      assign wrEn      = vS1;
      assign wrAddr    = aS1;
      assign frameDone = lS1;
    end else begin : g_lat
      logic [ARITH_LAT-1:0] dV, dL;
      logic [ADDR_W-1:0]    dA [ARITH_LAT];
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          dV <= '0;
          dL <= '0;
          for (int i = 0; i < ARITH_LAT; i++) dA[i] <= '0;
        end else begin
          dV[0] <= vS1;
          dL[0] <= lS1;
          dA[0] <= aS1;
          for (int i = 1; i < ARITH_LAT; i++) begin
            dV[i] <= dV[i-1];
            dL[i] <= dL[i-1];
            dA[i] <= dA[i-1];
          end
        end
      end
      assign wrEn      = dV[ARITH_LAT-1];
      assign wrAddr    = dA[ARITH_LAT-1];
      assign frameDone = dL[ARITH_LAT-1];
    end
  endgenerate
endmodule

// File: rtl/pixwin3_datapath.sv
module pixwin3_datapath
  import pixwin_pkg::*;
#(
  parameter int COLS  = 1024,
  parameter int PIX_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  pwStrobe_t          strb,
  input  logic [PIX_W-1:0]   pixIn,
  output logic [9*PIX_W-1:0] winPix
);
  // Two full lines plus two pixels behind the incoming one
  localparam int SR_LEN = 2 * COLS + 2;

  logic [PIX_W-1:0]   lineSr [SR_LEN];
  logic [9*PIX_W-1:0] taps;

  always_ff @(posedge clk) begin
    if (strb.shift) lineSr[0] <= pixIn;
  end

  genvar g;
  generate
    for (g = 1; g < SR_LEN; g++) begin : g_chain
      always_ff @(posedge clk) begin
        if (strb.shift) lineSr[g] <= lineSr[g-1];
      end
    end

    // Window slot k (P1 at k=0): rows top to bottom, columns left to right
    for (g = 0; g < 9; g++) begin : g_tap
      localparam int ROWU = g / 3;
      localparam int COLU = g % 3;
      localparam int DLY  = (2 - ROWU) * COLS + (2 - COLU);
      if (DLY == 0) begin : g_live
        assign taps[g*PIX_W +: PIX_W] = pixIn;
      end else begin : g_stored
        assign taps[g*PIX_W +: PIX_W] = lineSr[DLY-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         winPix <= '0;
    else if (strb.shift && strb.winOk) winPix <= taps;
    else                               winPix <= '0;
  end
endmodule

// File: rtl/pixwin3.sv
module pixwin3
  import pixwin_pkg::*;
#(
  parameter int COLS      = 1024,
  parameter int ROWS      = 1024,
  parameter int PIX_W     = 8,
  parameter int ARITH_LAT = 2,
  localparam int ADDR_W   = $clog2((ROWS - 2) * (COLS - 2))
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sof,
  input  logic [PIX_W-1:0]   pixIn,
  output logic [9*PIX_W-1:0] winPix,
  output logic               winValid,
  output logic               wrEn,
  output logic [ADDR_W-1:0]  wrAddr,
  output logic               frameDone
);
  pwStrobe_t strb;

  pixwin3_ctrl #(
    .COLS(COLS), .ROWS(ROWS), .ARITH_LAT(ARITH_LAT), .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .sof(sof), .strb(strb),
    .winValid(winValid), .wrEn(wrEn), .wrAddr(wrAddr), .frameDone(frameDone)
  );

  pixwin3_datapath #(
    .COLS(COLS), .PIX_W(PIX_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .pixIn(pixIn), .winPix(winPix)
  );
endmodule

// File: rtl/pixwin3_chk.sv
module pixwin3_chk #(
  parameter int COLS   = 1024,
  parameter int ROWS   = 1024,
  parameter int PIX_W  = 8,
  parameter int ADDR_W = 20
) (
  input logic               clk,
  input logic               rstN,
  input logic [9*PIX_W-1:0] winPix,
  input logic               winValid,
  input logic               wrEn,
  input logic [ADDR_W-1:0]  wrAddr,
  input logic               frameDone
);
  localparam logic [ADDR_W-1:0] ADDR_LAST = ADDR_W'((ROWS - 2) * (COLS - 2) - 1);

  // R4
  mask_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !winValid |-> (winPix == '0));

  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && $past(wrEn)) |-> (wrAddr == ADDR_W'($past(wrAddr) + 1'b1)));

  // R5
  addr_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> (wrAddr <= ADDR_LAST));

  // R6
  idle_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> (wrAddr == '0));

  // R7
  done_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> (wrEn && wrAddr == ADDR_LAST));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);

  // R9
  always @(posedge clk) begin
    if (!rstN) begin
      reset_clear_chk: assert (!winValid && !wrEn && !frameDone && winPix == '0);
    end
  end
endmodule

bind pixwin3 pixwin3_chk #(
  .COLS(COLS), .ROWS(ROWS), .PIX_W(PIX_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rstN(rstN), .winPix(winPix), .winValid(winValid),
  .wrEn(wrEn), .wrAddr(wrAddr), .frameDone(frameDone)
);

// File: tb/pixwin3_bench.sv
`timescale 1ns/1ps
module pixwin3_bench;
  localparam int COLS   = 8;
  localparam int ROWS   = 6;
  localparam int PIX_W  = 8;
  localparam int LAT    = 2;
  localparam int TOTAL  = (ROWS - 2) * (COLS - 2);
  localparam int ADDR_W = $clog2(TOTAL);

  // Frame patterns: row multiplier, column multiplier, offset, aborted-prefix length
  localparam int NPAT = 3;
  localparam int PAT [NPAT][4] = '{
    '{3, 7, 11, 0},
    '{29, 13, 200, 30},
    '{1, 31, 0, 0}
  };

  logic clk = 1'b0;
  logic rstN, sof;
  logic [PIX_W-1:0]   pixIn;
  logic [9*PIX_W-1:0] winPix;
  logic winValid, wrEn, frameDone;
  logic [ADDR_W-1:0] wrAddr;

  always #5 clk = ~clk;

  pixwin3 #(.COLS(COLS), .ROWS(ROWS), .PIX_W(PIX_W), .ARITH_LAT(LAT)) u_pixwin3 (
    .clk(clk), .rstN(rstN), .sof(sof), .pixIn(pixIn), .winPix(winPix),
    .winValid(winValid), .wrEn(wrEn), .wrAddr(wrAddr), .frameDone(frameDone)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Bench model state
  int  img [ROWS][COLS];
  bit  mRun = 0;
  int  mRow = 0, mCol = 0, mAddr = 0;
  bit  hV [0:LAT];
  int  hA [0:LAT];
  bit  hL [0:LAT];
  int  obsValid = 0, obsDone = 0;
  bit  aborted = 0;

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_hist();
    for (int i = 0; i <= LAT; i++) begin
      hV[i] = 0; hA[i] = 0; hL[i] = 0;
    end
  endtask

  task automatic check_zero(string tag);
    chk({tag, " winValid"}, winValid, 0);
    chk({tag, " winPix"}, (winPix == '0) ? 0 : 1, 0);
    chk({tag, " wrEn"}, wrEn, 0);
    chk({tag, " wrAddr"}, wrAddr, 0);
    chk({tag, " frameDone"}, frameDone, 0);
  endtask

  // Drive one pixel, update model, check outputs after the edge
  task automatic step(bit s, logic [PIX_W-1:0] v);
    bit acc, ev, el;
    int r, c, ea;
    @(negedge clk);
    sof = s;
    pixIn = v;
    acc = s || mRun;
    r = s ? 0 : mRow;
    c = s ? 0 : mCol;
    if (s) mAddr = 0;
    ev = acc && r >= 2 && c >= 2;
    if (acc) img[r][c] = int'(v);
    ea = ev ? mAddr : 0;
    el = ev && (mAddr == TOTAL - 1);
    if (ev) mAddr++;
    if (acc) begin
      if (r == ROWS - 1 && c == COLS - 1) begin
        mRun = 0; mRow = 0; mCol = 0;
      end else begin
        mRun = 1;
        if (c == COLS - 1) begin mCol = 0; mRow = r + 1; end
        else begin mCol = c + 1; mRow = r; end
      end
    end
    for (int i = LAT; i > 0; i--) begin
      hV[i] = hV[i-1]; hA[i] = hA[i-1]; hL[i] = hL[i-1];
    end
    hV[0] = ev; hA[0] = ea; hL[0] = el;
    @(posedge clk);
    #2;
    if (winValid) obsValid++;
    if (frameDone) obsDone++;
    chk(acc ? "R3 winValid" : "R1 ignored pixel winValid", winValid, ev);
    if (ev) begin
      for (int k = 0; k < 9; k++)
        chk("R2 window byte", winPix[k*PIX_W +: PIX_W], img[r - 2 + k/3][c - 2 + k%3]);
    end else begin
      chk("R4 masked window", (winPix == '0) ? 0 : 1, 0);
    end
    chk("R6 wrEn", wrEn, hV[LAT]);
    chk(aborted ? "R8 wrAddr after restart" : "R5 wrAddr", wrAddr, hA[LAT]);
    chk("R7 frameDone", frameDone, hL[LAT]);
  endtask

  function automatic logic [PIX_W-1:0] patPix(int t, int r, int c);
    return PIX_W'(r * PAT[t][0] + c * PAT[t][1] + PAT[t][2]);
  endfunction

  initial begin
    clear_hist();
    rstN = 1'b0; sof = 1'b0; pixIn = '0;
    repeat (3) @(posedge clk);
    #2;
    check_zero("R9 reset state");
    @(negedge clk);
    rstN = 1'b1;

    // R1: pixels before any sof are ignored
    for (int n = 0; n < 5; n++) step(1'b0, PIX_W'(n * 17 + 3));

    // Pattern table walked by one loop
    for (int t = 0; t < NPAT; t++) begin
      if (PAT[t][3] > 0) begin
        for (int n = 0; n < PAT[t][3]; n++)
          step(n == 0, PIX_W'(n * 5 + 1));
        aborted = 1;
      end
      obsValid = 0;
      obsDone = 0;
      for (int n = 0; n < ROWS * COLS; n++)
        step(n == 0, patPix(t, n / COLS, n % COLS));
      // R1: pixels after frame end are ignored; also drains write pipe
      for (int n = 0; n < LAT + 4; n++) step(1'b0, PIX_W'(8'hA5 + n));
      chk("R5 valid windows per frame", obsValid, TOTAL);
      chk("R7 done pulses per frame", obsDone, 1);
      aborted = 0;
    end

    // R9: reset in the middle of a frame
    for (int n = 0; n < 25; n++) step(n == 0, PIX_W'(n * 9));
    @(negedge clk);
    rstN = 1'b0;
    sof = 1'b0;
    #1;
    check_zero("R9 reset mid-frame");
    @(negedge clk);
    rstN = 1'b1;
    mRun = 0; mRow = 0; mCol = 0; mAddr = 0;
    clear_hist();
    for (int n = 0; n < 30; n++) step(1'b0, PIX_W'(n + 40));

    // Checkerboard of extremes after reset
    obsValid = 0;
    obsDone = 0;
    for (int n = 0; n < ROWS * COLS; n++)
      step(n == 0, (((n / COLS) + (n % COLS)) % 2 == 1) ? 8'hFF : 8'h00);
    for (int n = 0; n < LAT + 2; n++) step(1'b0, 8'h3C);
    chk("R5 valid windows after reset", obsValid, TOTAL);
    chk("R7 done pulse after reset", obsDone, 1);

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule